// File: doc/BRIEF.md
# Host Command Request/Completion Handshake

This block sits between a host register bus and a set of command executors. The host writes a request register in which bits 0 to 3 each ask for one command and bit 4 asks for the pending interrupt to be cleared. The block arbitrates the raised bits by a fixed priority and hands one command at a time to the executors, using one-cycle start pulses and a shared done pulse. It reports progress in a read-only response register. Each command has a sticky completion bit. The response register also carries an interrupt flag, a busy mirror, a hold indication and a command-in-progress flag.

A command is raised by a 0-to-1 change of its request bit. Its completion bit stays at 1 until the host writes the request bit back to 0, so the host must always write 0, see the completion bit go low, and only then write 1 again. While the interrupt flag is set, only the clear request is accepted. Other raised commands wait until the flag is cleared.

Top module: `cmd_handshake`

## Requirements
- R1: After a synchronous reset, both registers read 0, `cmd_start` is 0 and no command is pending.
- R2: The request register is at address 0x49. Its bits 0–4 read back as written and bits 5–7 read as 0. The response register is at address 0x4A and ignores writes. `rd_data` updates on the clock edge that samples `rd_en` and holds its value while `rd_en` is low. Other addresses read 0.
- R3: A 0-to-1 change of request bit i (i = 0..3), written at clock edge E, produces a one-cycle pulse on `cmd_start[i]` starting at edge E+1 if the sequencer is idle. Writing a request bit that is already 1 starts nothing.
- R4: When several request bits are raised together, they are issued one at a time in the order bit 0, bit 1, bit 3, bit 2. The next command starts only after the current one has completed.
- R5: A `cmd_done` pulse sampled at edge D while a command runs sets response bit i at edge D+1. A `cmd_done` pulse while no command runs has no effect.
- R6: Response bit i (i = 0..3) stays at 1 while request bit i is 1. It clears on the edge after request bit i reads 0.
- R7: Response bit 7 is 1 from the edge a command in bits 0–4 is accepted until the edge it completes. For an interrupt clear this is exactly one cycle.
- R8: An `irq_event` pulse sets response bit 4 on the next edge. A 0-to-1 change of request bit 4 clears response bit 4 two edges after the write. Writing 0 to request bit 4 leaves response bit 4 unchanged.
- R9: An `irq_event` that arrives while request bit 4 is 1 is absorbed, and response bit 4 does not rise.
- R10: While response bit 4 is 1, raised request bits 0–3 stay pending and start nothing. They are issued after the flag is cleared.
- R11: Response bit 5 equals `busy_in` as sampled at the previous edge. Writing request bit 5 has no effect.
- R12: Response bit 6 equals `hold_state` while `hold_en` is 1, and 0 while `hold_en` is 0, both one edge late.
- R13: Writing 0 to a raised request bit before it is accepted withdraws it, and its command never starts.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| wr_en | input | 1 | Register write strobe |
| wr_addr | input | 8 | Write address |
| wr_data | input | 8 | Write data |
| rd_en | input | 1 | Register read strobe |
| rd_addr | input | 8 | Read address |
| rd_data | output | 8 | Registered read data |
| cmd_start | output | 4 | One-hot, one-cycle command start pulses |
| cmd_done | input | 1 | One-cycle completion pulse from the running executor |
| irq_event | input | 1 | One-cycle interrupt occurrence pulse |
| busy_in | input | 1 | Busy status to mirror |
| hold_en | input | 1 | Hold enabled |
| hold_state | input | 1 | Current hold status |

## Verification
The hardest case to reach is a raised command that must wait behind an interrupt. The stimulus first sets the interrupt flag, then raises bit 2. It then raises the clear bit in the same write that keeps bit 2 raised, so the clear and bit 2 compete in one arbitration round. With the clear bit still held high, a second interrupt is sent to exercise the absorb path. A withdrawal is reached by stalling the executor: done pulses are switched off, a second bit is raised behind the stalled command and then written back to 0 before the stalled command finishes.

// File: rtl/cmd_hs_pkg.sv
package cmd_hs_pkg;

  typedef enum logic [1:0] {
    SQ_IDLE = 2'd0,
    SQ_RUN  = 2'd1,
    SQ_FIN  = 2'd2,
    SQ_CLR  = 2'd3
  } seq_state_e;

  // Map a priority rank to a request slot. Rank 0 is the interrupt clear
  // (slot n_ext). The remaining ranks follow ascending slot order, with the
  // two highest external slots swapped.
  function automatic int unsigned prio_slot(input int unsigned rank,
                                            input int unsigned n_ext);
    int unsigned r;
    if (rank == 0) return n_ext;
    r = rank - 1;
    if (n_ext >= 2 && r == n_ext - 2) return n_ext - 1;
    if (n_ext >= 2 && r == n_ext - 1) return n_ext - 2;
    return r;
  endfunction

endpackage

// File: rtl/cmd_hs_reqreg.sv
module cmd_hs_reqreg #(
  parameter int unsigned N_REQ = 5
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             wr_req,
  input  logic [N_REQ-1:0] wdata,
  input  logic [N_REQ-1:0] take_oh,
  output logic [N_REQ-1:0] req_q,
  output logic [N_REQ-1:0] pend_q
);

  logic [N_REQ-1:0] kept;

  // accepted slots leave the pending set
  assign kept = pend_q & ~take_oh;

  always_ff @(posedge clk) begin
    if (rst) begin
      req_q  <= '0;
      pend_q <= '0;
    end else if (wr_req) begin
      req_q  <= wdata;
      // rising bits become pending; bits written low are withdrawn
      pend_q <= (kept & wdata) | (wdata & ~req_q);
    end else begin
      pend_q <= kept;
    end
  end

endmodule

// File: rtl/cmd_hs_arb.sv
module cmd_hs_arb
  import cmd_hs_pkg::*;
#(
  parameter int unsigned N_EXT = 4
) (
  input  logic [N_EXT:0] pend,
  input  logic           irq_active,
  output logic           gnt_vld,
  output logic [N_EXT:0] gnt_oh
);

  localparam int unsigned N_SLOT = N_EXT + 1;

  logic [N_SLOT-1:0] elig;
  logic [N_SLOT-1:0] ranked;
  logic [N_SLOT-1:0] first;
  logic [N_SLOT-1:0] clr_mask;

  assign clr_mask = {1'b1, {N_EXT{1'b0}}};
  // under an active interrupt only the clear slot may compete
  assign elig     = irq_active ? (pend & clr_mask) : pend;

  for (genvar r = 0; r < N_SLOT; r++) begin : g_rank
    localparam int unsigned SLOT = prio_slot(r, N_EXT);
    assign ranked[r] = elig[SLOT];
  end

  // isolate the lowest set rank
  assign first = ranked & ~(ranked - {{N_EXT{1'b0}}, 1'b1});

  for (genvar r = 0; r < N_SLOT; r++) begin : g_unrank
    localparam int unsigned SLOT = prio_slot(r, N_EXT);
    assign gnt_oh[SLOT] = first[r];
  end

  assign gnt_vld = |elig;

endmodule

// File: rtl/cmd_hs_seq.sv
module cmd_hs_seq
  import cmd_hs_pkg::*;
#(
  parameter int unsigned N_EXT = 4
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             gnt_vld,
  input  logic [N_EXT:0]   gnt_oh,
  input  logic             cmd_done,
  input  logic [N_EXT-1:0] req_lvl,
  output logic [N_EXT:0]   take_oh,
  output logic [N_EXT-1:0] cmd_start,
  output logic [N_EXT-1:0] done_q,
  output logic             active,
  output logic             clr_fire
);

  seq_state_e       state;
  logic [N_EXT-1:0] cur_oh;
  logic [N_EXT-1:0] set_v;
  logic             idle;

  assign idle     = (state == SQ_IDLE);
  assign take_oh  = (idle && gnt_vld) ? gnt_oh : '0;
  assign set_v    = (state == SQ_FIN) ? cur_oh : '0;
  assign clr_fire = (state == SQ_CLR);
  assign active   = !idle;

  always_ff @(posedge clk) begin
    if (rst) begin
      state     <= SQ_IDLE;
      cur_oh    <= '0;
      cmd_start <= '0;
      done_q    <= '0;
    end else begin
      cmd_start <= '0;
      // sticky completion bits fall only once the request level is low
      done_q    <= (done_q & req_lvl) | set_v;
      unique case (state)
        SQ_IDLE: begin
          if (gnt_vld) begin
            if (gnt_oh[N_EXT]) begin
              state <= SQ_CLR;
            end else begin
              state     <= SQ_RUN;
              cur_oh    <= gnt_oh[N_EXT-1:0];
              cmd_start <= gnt_oh[N_EXT-1:0];
            end
          end
        end
        SQ_RUN:  if (cmd_done) state <= SQ_FIN;
        SQ_FIN:  state <= SQ_IDLE;
        SQ_CLR:  state <= SQ_IDLE;
        default: state <= SQ_IDLE;
      endcase
    end
  end

endmodule

// File: rtl/cmd_hs_status.sv
module cmd_hs_status (
  input  logic clk,
  input  logic rst,
  input  logic irq_event,
  input  logic clr_fire,
  input  logic clr_req_lvl,
  input  logic busy_in,
  input  logic hold_en,
  input  logic hold_state,
  output logic irq_q,
  output logic busy_q,
  output logic hold_q
);

  logic irq_n;

  always_comb begin
    irq_n = irq_q;
    if (clr_fire) irq_n = 1'b0;
    // an event meeting a still-raised clear request is absorbed
    if (irq_event && !clr_req_lvl) irq_n = 1'b1;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      irq_q  <= 1'b0;
      busy_q <= 1'b0;
      hold_q <= 1'b0;
    end else begin
      irq_q  <= irq_n;
      busy_q <= busy_in;
      hold_q <= hold_en & hold_state;
    end
  end

endmodule

// File: rtl/cmd_handshake.sv
module cmd_handshake
  import cmd_hs_pkg::*;
#(
  parameter int unsigned      N_EXT     = 4,
  parameter int unsigned      ADDR_W    = 8,
  parameter logic [ADDR_W-1:0] REQ_ADDR  = 8'h49,
  parameter logic [ADDR_W-1:0] RESP_ADDR = 8'h4A,
  localparam int unsigned     REG_W     = N_EXT + 4
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              wr_en,
  input  logic [ADDR_W-1:0] wr_addr,
  input  logic [REG_W-1:0]  wr_data,
  input  logic              rd_en,
  input  logic [ADDR_W-1:0] rd_addr,
  output logic [REG_W-1:0]  rd_data,
  output logic [N_EXT-1:0]  cmd_start,
  input  logic              cmd_done,
  input  logic              irq_event,
  input  logic              busy_in,
  input  logic              hold_en,
  input  logic              hold_state
);

  localparam int unsigned N_REQ = N_EXT + 1;

  logic             wr_req;
  logic [N_REQ-1:0] req_q;
  logic [N_REQ-1:0] pend_q;
  logic [N_REQ-1:0] take_oh;
  logic [N_REQ-1:0] gnt_oh;
  logic             gnt_vld;
  logic [N_EXT-1:0] done_q;
  logic             active;
  logic             clr_fire;
  logic             irq_q;
  logic             busy_q;
  logic             hold_q;
  logic [REG_W-1:0] resp_w;
  logic [REG_W-1:0] req_rd;
  logic             unused_wr_hi;

  assign wr_req       = wr_en && (wr_addr == REQ_ADDR);
  assign unused_wr_hi = ^wr_data[REG_W-1:N_REQ];

  cmd_hs_reqreg #(.N_REQ(N_REQ)) u_reqreg (
    .clk    (clk),
    .rst    (rst),
    .wr_req (wr_req),
    .wdata  (wr_data[N_REQ-1:0]),
    .take_oh(take_oh),
    .req_q  (req_q),
    .pend_q (pend_q)
  );

  cmd_hs_arb #(.N_EXT(N_EXT)) u_arb (
    .pend      (pend_q),
    .irq_active(irq_q),
    .gnt_vld   (gnt_vld),
    .gnt_oh    (gnt_oh)
  );

  cmd_hs_seq #(.N_EXT(N_EXT)) u_seq (
    .clk      (clk),
    .rst      (rst),
    .gnt_vld  (gnt_vld),
    .gnt_oh   (gnt_oh),
    .cmd_done (cmd_done),
    .req_lvl  (req_q[N_EXT-1:0]),
    .take_oh  (take_oh),
    .cmd_start(cmd_start),
    .done_q   (done_q),
    .active   (active),
    .clr_fire (clr_fire)
  );

  cmd_hs_status u_status (
    .clk        (clk),
    .rst        (rst),
    .irq_event  (irq_event),
    .clr_fire   (clr_fire),
    .clr_req_lvl(req_q[N_EXT]),
    .busy_in    (busy_in),
    .hold_en    (hold_en),
    .hold_state (hold_state),
    .irq_q      (irq_q),
    .busy_q     (busy_q),
    .hold_q     (hold_q)
  );

  assign resp_w = {active, hold_q, busy_q, irq_q, done_q};
  assign req_rd = {{(REG_W-N_REQ){1'b0}}, req_q};

  always_ff @(posedge clk) begin
    if (rst) begin
      rd_data <= '0;
    end else if (rd_en) begin
      if (rd_addr == REQ_ADDR)       rd_data <= req_rd;
      else if (rd_addr == RESP_ADDR) rd_data <= resp_w;
      else                           rd_data <= '0;
    end
  end

endmodule

// File: rtl/cmd_handshake_chk.sv
module cmd_handshake_chk #(
  parameter int unsigned N_EXT = 4,
  localparam int unsigned REG_W = N_EXT + 4
) (
  input logic             clk,
  input logic             rst,
  input logic [N_EXT-1:0] cmd_start,
  input logic             irq_event,
  input logic             busy_in,
  input logic             hold_en,
  input logic [REG_W-1:0] resp,
  input logic [N_EXT:0]   req
);

  localparam int unsigned IRQ_B  = N_EXT;
  localparam int unsigned BUSY_B = N_EXT + 1;
  localparam int unsigned HOLD_B = N_EXT + 2;
  localparam int unsigned ACT_B  = N_EXT + 3;

  // R4: at most one command line starts at a time
  a_r4_single_start: assert property (@(posedge clk) disable iff (rst)
    $onehot0(cmd_start));

  // R7: a start pulse always coincides with the in-progress flag
  a_r7_active_with_start: assert property (@(posedge clk) disable iff (rst)
    (|cmd_start) |-> resp[ACT_B]);

  // R10: no start follows a cycle with the interrupt flag set
  a_r10_irq_gates: assert property (@(posedge clk) disable iff (rst)
    resp[IRQ_B] |=> (cmd_start == '0));

  // R9: an event meeting a raised clear request does not set the flag
  a_r9_absorb: assert property (@(posedge clk) disable iff (rst)
    (irq_event && req[N_EXT] && !resp[IRQ_B]) |=> !resp[IRQ_B]);

  // R11: busy mirror one edge late
  a_r11_busy_mirror: assert property (@(posedge clk) disable iff (rst)
    1'b1 |=> (resp[BUSY_B] == $past(busy_in)));

  // R12: hold indication forced low once hold is cancelled
  a_r12_hold_cancel: assert property (@(posedge clk) disable iff (rst)
    !hold_en |=> !resp[HOLD_B]);

  // R6: completion bits with their request still high stay set
  a_r6_done_sticky: assert property (@(posedge clk) disable iff (rst)
    1'b1 |=> ((resp[N_EXT-1:0] & $past(resp[N_EXT-1:0] & req[N_EXT-1:0]))
              == $past(resp[N_EXT-1:0] & req[N_EXT-1:0])));

endmodule

bind cmd_handshake cmd_handshake_chk #(.N_EXT(N_EXT)) u_chk (
  .clk      (clk),
  .rst      (rst),
  .cmd_start(cmd_start),
  .irq_event(irq_event),
  .busy_in  (busy_in),
  .hold_en  (hold_en),
  .resp     (resp_w),
  .req      (req_q)
);

// File: tb/cmd_handshake_bench.sv
module cmd_handshake_bench;

  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic       wr_en = 1'b0;
  logic [7:0] wr_addr = 8'h00;
  logic [7:0] wr_data = 8'h00;
  logic       rd_en = 1'b1;
  logic [7:0] rd_addr = 8'h4A;
  logic [7:0] rd_data;
  logic [3:0] cmd_start;
  logic       cmd_done;
  logic       auto_done = 1'b0;
  logic       man_done = 1'b0;
  logic       irq_event = 1'b0;
  logic       busy_in = 1'b0;
  logic       hold_en = 1'b0;
  logic       hold_state = 1'b0;

  always #5 clk = ~clk;

  assign cmd_done = auto_done | man_done;

  cmd_handshake u_cmd_handshake (
    .clk(clk), .rst(rst), .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data),
    .rd_en(rd_en), .rd_addr(rd_addr), .rd_data(rd_data), .cmd_start(cmd_start),
    .cmd_done(cmd_done), .irq_event(irq_event), .busy_in(busy_in),
    .hold_en(hold_en), .hold_state(hold_state)
  );

  int    n_tests = 0;
  int    n_fail  = 0;
  int    cyc     = 0;
  bit    started = 1'b0;
  bit    done_run = 1'b0;
  string cur_req = "R1";

  // behavioural reference state
  logic [4:0] m_req, m_pend, m_take, m_p;
  logic [3:0] m_done, m_set, m_start, n_start;
  logic       m_irq, n_irq, m_busy, m_hold;
  logic [7:0] m_rd, m_resp;
  int         m_phase, n_phase, m_idx, pick;
  int         order[5] = '{4, 0, 1, 3, 2};

  always @(posedge clk) begin
    started <= 1'b1;
    if (rst) begin
      m_req = '0; m_pend = '0; m_done = '0; m_irq = 0; m_busy = 0; m_hold = 0;
      m_rd = '0; m_start = '0; m_phase = 0; m_idx = 0;
    end else begin
      m_resp = {m_phase != 0, m_hold, m_busy, m_irq, m_done};
      if (rd_en) m_rd = (rd_addr == 8'h49) ? {3'b000, m_req} :
                        (rd_addr == 8'h4A) ? m_resp : 8'h00;
      n_start = '0; m_take = '0; m_set = '0; n_phase = m_phase; n_irq = m_irq;
      case (m_phase)
        0: begin
          pick = -1;
          for (int k = 0; k < 5; k++)
            if (pick < 0 && m_pend[order[k]] && (!m_irq || order[k] == 4)) pick = order[k];
          if (pick == 4) begin n_phase = 3; m_take[4] = 1'b1; end
          else if (pick >= 0) begin
            n_phase = 1; m_idx = pick; n_start[pick] = 1'b1; m_take[pick] = 1'b1;
          end
        end
        1: if (cmd_done) n_phase = 2;
        2: begin n_phase = 0; m_set[m_idx] = 1'b1; end
        default: begin n_phase = 0; n_irq = 1'b0; end
      endcase
      if (irq_event && !m_req[4]) n_irq = 1'b1;
      m_done = (m_done & m_req[3:0]) | m_set;
      m_p = m_pend & ~m_take;
      if (wr_en && wr_addr == 8'h49) begin
        m_p = (m_p & wr_data[4:0]) | (wr_data[4:0] & ~m_req);
        m_req = wr_data[4:0];
      end
      m_pend = m_p; m_phase = n_phase; m_irq = n_irq; m_start = n_start;
      m_busy = busy_in; m_hold = hold_en & hold_state;
    end
  end

  // compare every cycle, then model the executor
  int lat = 2;
  int cnt = 0;
  bit auto_en = 1'b1;
  always @(negedge clk) begin
    if (started && !done_run) begin
      n_tests++;
      if (rd_data !== m_rd) begin
        n_fail++;
        $display("FAIL %s rd_data actual=%h expected=%h (cycle %0d)", cur_req, rd_data, m_rd, cyc);
      end
      n_tests++;
      if (cmd_start !== m_start) begin
        n_fail++;
        $display("FAIL %s cmd_start actual=%b expected=%b (cycle %0d)", cur_req, cmd_start, m_start, cyc);
      end
    end
    auto_done = 1'b0;
    if (auto_en && cmd_start != 0) cnt = lat;
    else if (cnt > 0) begin
      cnt--;
      if (cnt == 0) auto_done = 1'b1;
    end
  end

  task automatic finish_run();
    done_run = 1'b1;
    $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  endtask

  always @(posedge clk) begin
    cyc++;
    if (cyc > 20000 && !done_run) begin
      n_fail++;
      $display("FAIL watchdog actual=%0d cycles expected<=20000", cyc);
      finish_run();
    end
  end

  task automatic wait_n(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic wr(input logic [7:0] a, input logic [7:0] d);
    @(negedge clk); wr_en = 1'b1; wr_addr = a; wr_data = d;
    @(negedge clk); wr_en = 1'b0;
  endtask

  task automatic read_req();
    @(negedge clk); rd_addr = 8'h49;
    @(negedge clk); rd_addr = 8'h4A;
  endtask

  task automatic pulse_irq();
    @(negedge clk); irq_event = 1'b1;
    @(negedge clk); irq_event = 1'b0;
  endtask

  task automatic pulse_done();
    @(negedge clk); man_done = 1'b1;
    @(negedge clk); man_done = 1'b0;
  endtask

  initial begin
    cur_req = "R1";
    wait_n(3); rst = 1'b0;
    wait_n(2); read_req(); wait_n(2);

    cur_req = "R3";
    wr(8'h49, 8'h01); wait_n(8);
    wr(8'h49, 8'h01); wait_n(6);        // held 1: no restart

    cur_req = "R6";
    wr(8'h49, 8'h00); wait_n(3);
    wr(8'h49, 8'h01); wait_n(8);
    wr(8'h49, 8'h00); wait_n(3);

    cur_req = "R4";
    wr(8'h49, 8'h0F); wait_n(30);
    read_req();
    wr(8'h49, 8'h00); wait_n(3);

    cur_req = "R13";
    auto_en = 1'b0;
    wr(8'h49, 8'h01); wait_n(3);
    wr(8'h49, 8'h03); wait_n(2);
    wr(8'h49, 8'h01); wait_n(2);
    pulse_done(); wait_n(10);
    wr(8'h49, 8'h00); wait_n(3);

    cur_req = "R5";
    pulse_done(); wait_n(4);
    auto_en = 1'b1;

    cur_req = "R10";
    pulse_irq(); wait_n(2);
    wr(8'h49, 8'h04); wait_n(8);        // bit 2 held off
    cur_req = "R8";
    wr(8'h49, 8'h14); wait_n(10);       // clear, then bit 2 runs
    cur_req = "R9";
    pulse_irq(); wait_n(3);
    wr(8'h49, 8'h00); wait_n(3);
    cur_req = "R8";
    pulse_irq(); wait_n(2);
    wr(8'h49, 8'h00); wait_n(3);        // writing 0 to bit 4 ignored
    cur_req = "R7";
    wr(8'h49, 8'h10); wait_n(4);
    wr(8'h49, 8'h00); wait_n(2);

    cur_req = "R11";
    busy_in = 1'b1; wait_n(3);
    wr(8'h49, 8'hE0); read_req();       // bits 5-7 not stored
    busy_in = 1'b0; wait_n(3);

    cur_req = "R2";
    wr(8'h4A, 8'hFF); wait_n(2);
    rd_addr = 8'h10; wait_n(2);
    rd_en = 1'b0; rd_addr = 8'h4A; busy_in = 1'b1; wait_n(3);
    rd_en = 1'b1; wait_n(2); busy_in = 1'b0;

    cur_req = "R12";
    hold_en = 1'b1; hold_state = 1'b1; wait_n(3);
    hold_state = 1'b0; wait_n(2);
    hold_state = 1'b1; wait_n(2);
    hold_en = 1'b0; wait_n(3);

    finish_run();
  end

endmodule